// File: doc/BRIEF.md
# NAND Single-Bit ECC Corrector

This block checks one 512-byte flash data chunk after it has been read. It takes two codes. The first is the 24-bit parity code stored in the spare area, given as three bytes. The second is the raw 32-bit parity word that the streaming parity logic produced while the chunk was read. From the raw word it builds its own 24-bit code: two 12-bit parity fields placed side by side and then bit-inverted, the same form in which the code is stored. It XORs this code with the stored one to get a difference word, and from that word it decides among four outcomes:

- the chunk is clean;
- one data bit is wrong and can be located;
- only the stored code is damaged;
- the damage cannot be corrected.

For a locatable data-bit error the block reports the byte index and the bit number. A small local byte buffer holds the start of the chunk. When the caller asks for it and the byte lies inside that buffer, the block flips the faulty bit in place with a read-modify-write before it signals completion. A one-cycle done pulse marks the moment the status and the location become valid. Both then stay unchanged until the next check completes.

Top module: `ecc1_fixer`

## Requirements
- R1: The computed code is the bitwise inverse of {calc_parity[27:16], calc_parity[11:0]}. The difference word is stored_code XOR that code. stored_code[7:0] holds the first stored byte, [15:8] the second and [23:16] the third. A zero difference gives status 2'b00 (clean).
- R2: If difference[23:12] XOR difference[11:0] equals 12'hFFF and difference[23:15] is below CHUNK_BYTES, the status is 2'b01 (data corrected). In that case err_byte = difference[23:15] and err_bit = difference[14:12].
- R3: If the complementary-halves test holds but difference[23:15] is not below CHUNK_BYTES, the status is 2'b11 (uncorrectable).
- R4: If exactly one bit of the difference is set, the status is 2'b10 (stored-code error), and the buffer is left unchanged even when fix_en is set.
- R5: Any other nonzero difference gives status 2'b11.
- R6: Whenever the published status is not 2'b01, err_byte and err_bit read zero.
- R7: A check is accepted when start is high on a clock edge while the block is idle. If no correction is applied, done is high for exactly one cycle, one edge after the accepting edge. status, err_byte and err_bit change only on the edge that raises done.
- R8: A correction is applied when fix_en was high at acceptance, the status is 2'b01 and err_byte is below BUF_BYTES. The buffer byte at err_byte is then XORed with (1 << err_bit), and done rises three edges after the accepting edge. If fix_en was low, or err_byte lies outside the buffer, the buffer is not touched.
- R9: start is ignored while a check is in progress. External buffer writes take effect only while the block is idle.
- R10: While reset is active, done is 0, status is 2'b00 and err_byte and err_bit are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Strobe that begins a check |
| fix_en | input | 1 | Apply a correctable flip to the local buffer |
| stored_code | input | 24 | Stored code bytes, first byte in bits 7:0 |
| calc_parity | input | 32 | Raw parity word computed during the read |
| buf_we | input | 1 | External buffer write enable |
| buf_addr | input | BUF_AW | External buffer address, used for both reads and writes |
| buf_wdata | input | 8 | External buffer write data |
| buf_rdata | output | 8 | Buffer byte at buf_addr |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 00 clean, 01 corrected, 10 stored-code error, 11 uncorrectable |
| err_byte | output | 9 | Byte index of a corrected data-bit error |
| err_bit | output | 3 | Bit number within that byte |

## Verification
A corrupted difference register or a wrong classification shows on status and the location outputs at the very edge that raises done, one or three cycles after the check is accepted. A faulty state sequence shows first as done arriving at the wrong edge, or as a second start being accepted too early. A bad read-modify-write stays hidden until the buffer is read back through buf_rdata, so every buffer byte is read back after each check that could have written it.

// File: rtl/ecc1_pkg.sv
package ecc1_pkg;
  localparam int CODE_W = 24;
  localparam int HALF_W = 12;
  localparam int BYTE_IDX_W = 9;
  localparam int BIT_IDX_W = 3;

  typedef enum logic [1:0] {
    ST_CLEAN = 2'b00,
    ST_FIXED = 2'b01,
    ST_CODE  = 2'b10,
    ST_BAD   = 2'b11
  } ecc_status_e;

  // Build the stored-form code from the raw parity word: two 12-bit fields, inverted.
  function automatic logic [CODE_W-1:0] pack_code(input logic [31:0] raw);
    return ~{raw[16 +: HALF_W], raw[0 +: HALF_W]};
  endfunction
endpackage

// File: rtl/ecc1_classify.sv
module ecc1_classify
  import ecc1_pkg::*;
#(
  parameter int CHUNK_BYTES = 512
) (
  input  logic [CODE_W-1:0]     diff,
  output ecc_status_e           cls_status,
  output logic [BYTE_IDX_W-1:0] cls_byte,
  output logic [BIT_IDX_W-1:0]  cls_bit
);
  logic [HALF_W-1:0] halves_x;
  logic              comp_halves;
  logic              single_bit;

  assign halves_x    = diff[CODE_W-1:HALF_W] ^ diff[HALF_W-1:0];
  assign comp_halves = &halves_x;
  assign single_bit  = (diff != '0) && ((diff & (diff - 1'b1)) == '0);
  assign cls_byte    = diff[CODE_W-1 -: BYTE_IDX_W];
  assign cls_bit     = diff[HALF_W +: BIT_IDX_W];

  always_comb begin
    if (diff == '0) begin
      cls_status = ST_CLEAN;
    end else if (comp_halves) begin
      cls_status = (int'(cls_byte) < CHUNK_BYTES) ? ST_FIXED : ST_BAD;
    end else if (single_bit) begin
      cls_status = ST_CODE;
    end else begin
      cls_status = ST_BAD;
    end
  end
endmodule

// File: rtl/ecc1_bytebuf.sv
module ecc1_bytebuf #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_addr_a,
  output logic [7:0]    rd_data_a,
  input  logic [AW-1:0] rd_addr_b,
  output logic [7:0]    rd_data_b
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem_q[wr_addr] <= wr_data;
    end
  end

  assign rd_data_a = mem_q[rd_addr_a];
  assign rd_data_b = mem_q[rd_addr_b];
endmodule

// File: rtl/ecc1_fixer.sv
module ecc1_fixer
  import ecc1_pkg::*;
#(
  parameter int CHUNK_BYTES = 512,
  parameter int BUF_BYTES = 16,
  localparam int BUF_AW = $clog2(BUF_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              fix_en,
  input  logic [23:0]       stored_code,
  input  logic [31:0]       calc_parity,
  input  logic              buf_we,
  input  logic [BUF_AW-1:0] buf_addr,
  input  logic [7:0]        buf_wdata,
  output logic [7:0]        buf_rdata,
  output logic              done,
  output logic [1:0]        status,
  output logic [8:0]        err_byte,
  output logic [2:0]        err_bit
);
  typedef enum logic [1:0] {S_IDLE, S_EVAL, S_READ, S_WRITE} state_e;

  // Reset: asserted asynchronously, released on the clock.
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  state_e                state_q, state_d;
  logic [CODE_W-1:0]     diff_q, diff_d;
  logic                  fix_q, fix_d;
  logic [7:0]            tmp_q, tmp_d;
  logic                  done_q, done_d;
  ecc_status_e           status_q, status_d;
  logic [BYTE_IDX_W-1:0] byte_q, byte_d;
  logic [BIT_IDX_W-1:0]  bit_q, bit_d;

  ecc_status_e           cls_status;
  logic [BYTE_IDX_W-1:0] cls_byte;
  logic [BIT_IDX_W-1:0]  cls_bit;
  logic                  apply_fix;
  logic                  fix_we;
  logic [BUF_AW-1:0]     fix_addr;
  logic [7:0]            fix_rdata;
  logic                  mem_we;
  logic [BUF_AW-1:0]     mem_waddr;
  logic [7:0]            mem_wdata;

  ecc1_classify #(.CHUNK_BYTES(CHUNK_BYTES)) u_cls (
    .diff       (diff_q),
    .cls_status (cls_status),
    .cls_byte   (cls_byte),
    .cls_bit    (cls_bit)
  );

  assign apply_fix = fix_q && (cls_status == ST_FIXED) && (int'(cls_byte) < BUF_BYTES);
  assign fix_addr  = cls_byte[BUF_AW-1:0];
  assign fix_we    = (state_q == S_WRITE);
  assign mem_we    = fix_we || (buf_we && (state_q == S_IDLE));
  assign mem_waddr = fix_we ? fix_addr : buf_addr;
  assign mem_wdata = fix_we ? tmp_q : buf_wdata;

  ecc1_bytebuf #(.DEPTH(BUF_BYTES)) u_buf (
    .clk       (clk),
    .wr_en     (mem_we),
    .wr_addr   (mem_waddr),
    .wr_data   (mem_wdata),
    .rd_addr_a (buf_addr),
    .rd_data_a (buf_rdata),
    .rd_addr_b (fix_addr),
    .rd_data_b (fix_rdata)
  );

  always_comb begin
    state_d  = state_q;
    diff_d   = diff_q;
    fix_d    = fix_q;
    tmp_d    = tmp_q;
    done_d   = 1'b0;
    status_d = status_q;
    byte_d   = byte_q;
    bit_d    = bit_q;
    unique case (state_q)
      S_IDLE: begin
        if (start) begin
          diff_d  = stored_code ^ pack_code(calc_parity);
          fix_d   = fix_en;
          state_d = S_EVAL;
        end
      end
      S_EVAL: begin
        if (apply_fix) begin
          state_d = S_READ;
        end else begin
          done_d   = 1'b1;
          status_d = cls_status;
          byte_d   = (cls_status == ST_FIXED) ? cls_byte : '0;
          bit_d    = (cls_status == ST_FIXED) ? cls_bit : '0;
          state_d  = S_IDLE;
        end
      end
      S_READ: begin
        tmp_d   = fix_rdata ^ (8'b1 << cls_bit);
        state_d = S_WRITE;
      end
      S_WRITE: begin
        done_d   = 1'b1;
        status_d = cls_status;
        byte_d   = cls_byte;
        bit_d    = cls_bit;
        state_d  = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q  <= S_IDLE;
      diff_q   <= '0;
      fix_q    <= 1'b0;
      tmp_q    <= '0;
      done_q   <= 1'b0;
      status_q <= ST_CLEAN;
      byte_q   <= '0;
      bit_q    <= '0;
    end else begin
      state_q  <= state_d;
      diff_q   <= diff_d;
      fix_q    <= fix_d;
      tmp_q    <= tmp_d;
      done_q   <= done_d;
      status_q <= status_d;
      byte_q   <= byte_d;
      bit_q    <= bit_d;
    end
  end

  assign done     = done_q;
  assign status   = status_q;
  assign err_byte = byte_q;
  assign err_bit  = bit_q;
endmodule

// File: rtl/ecc1_fixer_chk.sv
module ecc1_fixer_chk #(
  parameter int CHUNK_BYTES = 512,
  parameter int BUF_BYTES = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic       done,
  input logic [1:0] status,
  input logic [8:0] err_byte,
  input logic [2:0] err_bit,
  input logic       fix_we
);
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(status) && $stable(err_byte) && $stable(err_bit)));

  a_r6_loc_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status != 2'b01) |-> (err_byte == 9'd0 && err_bit == 3'd0));

  a_r2_index_in_chunk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status == 2'b01) |-> (int'(err_byte) < CHUNK_BYTES));

  a_r8_write_then_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    fix_we |=> (done && status == 2'b01 && int'(err_byte) < BUF_BYTES));
endmodule

bind ecc1_fixer ecc1_fixer_chk #(
  .CHUNK_BYTES (CHUNK_BYTES),
  .BUF_BYTES   (BUF_BYTES)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .done     (done),
  .status   (status),
  .err_byte (err_byte),
  .err_bit  (err_bit),
  .fix_we   (fix_we)
);

// File: tb/ecc1_fixer_test.sv
`timescale 1ns/1ps
module ecc1_fixer_test;
  localparam int CHUNK = 256;
  localparam int NBUF = 16;
  localparam int AW = $clog2(NBUF);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          fix_en = 1'b0;
  logic [23:0]   stored_code = '0;
  logic [31:0]   calc_parity = '0;
  logic          buf_we = 1'b0;
  logic [AW-1:0] buf_addr = '0;
  logic [7:0]    buf_wdata = '0;
  logic [7:0]    buf_rdata;
  logic          done;
  logic [1:0]    status;
  logic [8:0]    err_byte;
  logic [2:0]    err_bit;

  int n_checks = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  ecc1_fixer #(.CHUNK_BYTES(CHUNK), .BUF_BYTES(NBUF)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .fix_en(fix_en),
    .stored_code(stored_code), .calc_parity(calc_parity),
    .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
    .buf_rdata(buf_rdata), .done(done), .status(status),
    .err_byte(err_byte), .err_bit(err_bit)
  );

  // Reference model state
  int         pend = 0;
  logic       exp_done = 1'b0;
  int         exp_st = 0;
  int         exp_byte = 0;
  int         exp_bit = 0;
  int         nx_st = 0;
  int         nx_byte = 0;
  int         nx_bit = 0;
  bit         nx_fix = 1'b0;
  logic [7:0] exp_mem [NBUF];

  function automatic logic [23:0] ref_code(input logic [31:0] p);
    logic [23:0] c;
    c[11:0]  = p[11:0];
    c[23:12] = p[27:16];
    return ~c;
  endfunction

  always @(posedge clk) begin
    bit was_idle;
    was_idle = (pend == 0);
    exp_done = 1'b0;
    if (!uut.rst_sync_n) begin
      pend = 0; exp_st = 0; exp_byte = 0; exp_bit = 0;
    end else if (pend > 0) begin
      pend = pend - 1;
      if (pend == 0) begin
        exp_done = 1'b1;
        exp_st = nx_st;
        exp_byte = (nx_st == 1) ? nx_byte : 0;
        exp_bit = (nx_st == 1) ? nx_bit : 0;
        if (nx_fix) exp_mem[nx_byte] = exp_mem[nx_byte] ^ (8'd1 << nx_bit);
      end
    end else if (start) begin
      logic [23:0] d;
      d = stored_code ^ ref_code(calc_parity);
      nx_byte = int'(d >> 15);
      nx_bit = int'((d >> 12) & 24'd7);
      if (d == 0) nx_st = 0;
      else if ((((d >> 12) ^ d) & 24'hFFF) == 24'hFFF) nx_st = (nx_byte < CHUNK) ? 1 : 3;
      else if ($countones(d) == 1) nx_st = 2;
      else nx_st = 3;
      nx_fix = fix_en && nx_st == 1 && nx_byte < NBUF;
      pend = nx_fix ? 3 : 1;
    end
    if (uut.rst_sync_n && was_idle && buf_we) exp_mem[buf_addr] = buf_wdata;
  end

  function automatic string tag_of(input int st);
    case (st)
      0: return "R1";
      1: return "R2";
      2: return "R4";
      default: return "R5/R3";
    endcase
  endfunction

  // Per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (!rst_n) begin
      n_checks++;
      if (done !== 1'b0 || status !== 2'b00 || err_byte !== 9'd0 || err_bit !== 3'd0) begin
        n_fail++;
        $display("FAIL R10 reset: done=%b st=%b byte=%0d bit=%0d exp 0/00/0/0",
                 done, status, err_byte, err_bit);
      end
    end else begin
      n_checks++;
      if (done !== exp_done || status !== 2'(exp_st) || err_byte !== 9'(exp_byte) ||
          err_bit !== 3'(exp_bit)) begin
        n_fail++;
        $display("FAIL %s/R6/R7 t=%0t: done=%b st=%b byte=%0d bit=%0d exp done=%b st=%0d byte=%0d bit=%0d",
                 exp_done ? tag_of(exp_st) : "R7", $time, done, status, err_byte, err_bit,
                 exp_done, exp_st, exp_byte, exp_bit);
      end
    end
  end

  task automatic run(input logic [31:0] calc, input logic [23:0] diff, input bit fx);
    @(negedge clk);
    calc_parity = calc;
    stored_code = diff ^ ref_code(calc);
    fix_en = fx;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic check_buf(input string req);
    for (int i = 0; i < NBUF; i++) begin
      @(negedge clk);
      buf_addr = AW'(i);
      #1;
      n_checks++;
      if (buf_rdata !== exp_mem[i]) begin
        n_fail++;
        $display("FAIL %s buffer[%0d]: got %h exp %h", req, i, buf_rdata, exp_mem[i]);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < NBUF; i++) begin
      buf_we = 1'b1; buf_addr = AW'(i); buf_wdata = 8'(i * 17 + 3);
      @(negedge clk);
    end
    buf_we = 1'b0;
    check_buf("R9");
    run(32'h0ABC_0123, 24'h000000, 1'b1);   // R1 clean
    run(32'h1234_5678, 24'h02BFD4, 1'b1);   // R2/R8 byte 5 bit 3, applied
    check_buf("R8");
    run(32'h0F0F_F0F0, 24'h6479B8, 1'b1);   // R2 byte 200 outside buffer
    check_buf("R8");
    run(32'h5555_AAAA, 24'h96169E, 1'b0);   // R3 byte 300 >= chunk
    run(32'h0000_0000, 24'h000400, 1'b1);   // R4 stored-code error
    check_buf("R4");
    run(32'hFFFF_FFFF, 24'h000003, 1'b0);   // R5 two bits
    run(32'h0101_0101, 24'h010FEF, 1'b0);   // R8 fix disabled, byte 2 bit 0
    check_buf("R8");
    // R9: second start during a busy correction is ignored
    @(negedge clk);
    calc_parity = 32'h3333_4444;
    stored_code = 24'h07CF83 ^ ref_code(32'h3333_4444); // byte 15 bit 4
    fix_en = 1'b1; start = 1'b1;
    @(negedge clk);
    stored_code = 24'h000003; fix_en = 1'b0;
    @(negedge clk);
    start = 1'b0;
    repeat (6) @(negedge clk);
    check_buf("R9");
    run(32'h0000_0000, 24'h000000, 1'b0);   // back-to-back clean after busy
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, exp completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule